// File: doc/BRIEF.md
# Run-Length NRZI Packet Receiver

This block turns the demodulated tone-select line of a 1200 baud packet radio link back into bytes. A clock enable, `tick`, marks sample points at four times the baud rate. The receiver does not try to place a sample in the middle of each bit. It synchronises the tone line, measures how many ticks pass between tone changes, and rounds that count to a whole number of bit periods. In this line code a tone change means a zero and a steady tone means a one. An interval of N bit periods therefore stands for one zero followed by N-1 ones.

The length of each interval decides how it is handled. A run of six periods means the zero that follows was inserted by the sender, so it is removed. A run of seven periods is the frame delimiter. A longer run is an abort. Data bits are assembled least significant bit first, and each completed byte is reported with a one-cycle strobe. The receiver stays idle after reset and after an abort, and it only starts producing bytes once it has seen a delimiter. CRC checking, address filtering and buffering belong to the blocks that follow it.

Top module: `ax25rx_top`

## Requirements
- R1: `tone_in` passes through a two-flop synchroniser and is examined only on cycles with `tick` high. Every output strobe appears in the cycle after a cycle in which `tick` was high.
- R2: When the synchronised tone differs from its value at the previous tick, the elapsed tick count c is converted to N = (c + 2) / 4 bit periods, using integer division. A result of 0 is taken as 1. The count then restarts at 1 for that tick.
- R3: Inside a frame, an interval of N periods with N from 1 to 6 feeds one zero and then N-1 ones into the byte assembler. Each bit enters at bit 7 while the byte shifts right, so the first bit received ends up in bit 0.
- R4: After every eighth assembled bit, `byte_vld` pulses for one cycle and `byte_data` holds the byte.
- R5: After an interval of exactly 6 periods, the zero that opens the next interval is discarded.
- R6: An interval of exactly 7 periods pulses `flag_det`, clears any partial byte, starts a new byte boundary, enters the in-frame state, and discards the zero that opens the next interval.
- R7: Inside a frame, a run with no tone change that reaches 8 bit periods pulses `abort_det` once. It discards the partial byte and returns the receiver to idle.
- R8: The abort fires as soon as 30 ticks have passed without a tone change, at the tick that makes the gap certain to round to 8 or more. The tick counter saturates there.
- R9: After reset, and after an abort, the receiver is idle: no byte is reported until a 7-period delimiter is seen. Reset drives all strobes low.
- R10: At most one of `byte_vld`, `flag_det` and `abort_det` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample enable at four times the baud rate |
| tone_in | input | 1 | Demodulated tone-select level, asynchronous |
| byte_vld | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Received byte, valid with `byte_vld` |
| flag_det | output | 1 | One-cycle strobe for a frame delimiter |
| abort_det | output | 1 | One-cycle strobe for an abort |

## Verification
The bench builds the block with its default parameters: four ticks per bit, a 7-period delimiter, 8-bit bytes and two synchroniser stages. It drives `tick` high only on every other clock. It also shifts each tone interval by -1, 0 or +1 tick in rotation, so both the tick gating and the rounding at either side of the nominal length are exercised. The payload includes 0xFF and 0x7E, which force inserted zeros. It includes two aborts caused by a long steady tone. It also sends a byte between an abort and the next delimiter, which must not appear on the outputs.

// File: rtl/ax25rx_pkg.sv
package ax25rx_pkg;

  localparam int OVS_DEF      = 4;
  localparam int FLAG_LEN_DEF = 7;
  localparam int DW_DEF       = 8;

  // Tick count at which a gap is certain to round to FLAG_LEN+1 periods.
  function automatic int sat_ticks(input int ovs, input int flag_len);
    return ovs * (flag_len + 1) - ovs / 2;
  endfunction

  // Width able to hold a run length up to FLAG_LEN+1.
  function automatic int len_width(input int flag_len);
    return $clog2(flag_len + 2);
  endfunction

endpackage

// File: rtl/ax25rx_sync.sv
module ax25rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign d_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ax25rx_runlen.sv
module ax25rx_runlen
  import ax25rx_pkg::*;
#(
  parameter int OVS      = OVS_DEF,
  parameter int FLAG_LEN = FLAG_LEN_DEF,
  localparam int SAT     = sat_ticks(OVS, FLAG_LEN),
  localparam int CW      = $clog2(SAT + 1),
  localparam int LW      = len_width(FLAG_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          din,
  output logic          ev_run,
  output logic [LW-1:0] ev_len,
  output logic          ev_sat
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          last_q, last_d;
  logic          edge_seen;
  int            quot;

  always_comb begin
    edge_seen = tick && (din != last_q);
    last_d    = tick ? din : last_q;
    cnt_d     = cnt_q;
    if (tick) begin
      if (edge_seen)                cnt_d = CW'(1);
      else if (cnt_q < CW'(SAT))    cnt_d = cnt_q + CW'(1);
    end
    quot = (int'(cnt_q) + OVS / 2) / OVS;
    if (quot < 1) quot = 1;
    ev_run = edge_seen;
    ev_len = LW'(quot);
    ev_sat = tick && !edge_seen && (cnt_q == CW'(SAT - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CW'(SAT);
      last_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(SAT)) else $error("tick counter past saturation"); // R8

  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(SAT) && !(tick && din != last_q)) |=> cnt_q == CW'(SAT))
    else $error("saturated counter moved without an edge"); // R8

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_run |-> ev_len != '0) else $error("zero-length run"); // R2

endmodule

// File: rtl/ax25rx_deframe.sv
module ax25rx_deframe
  import ax25rx_pkg::*;
#(
  parameter int FLAG_LEN = FLAG_LEN_DEF,
  parameter int DW       = DW_DEF,
  localparam int LW      = len_width(FLAG_LEN),
  localparam int LFW     = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_run,
  input  logic [LW-1:0] ev_len,
  input  logic          ev_sat,
  output logic          byte_vld,
  output logic [DW-1:0] byte_data,
  output logic          flag_det,
  output logic          abort_det
);

  logic [DW-1:0]  sr_q, sr_n, bd_q, bd_n;
  logic [LFW-1:0] left_q, left_n;
  logic           act_q, act_n, drop_q, drop_n;
  logic           bv_q, bv_n, fl_q, fl_n, ab_q, ab_n;

  always_comb begin
    sr_n   = sr_q;
    left_n = left_q;
    act_n  = act_q;
    drop_n = drop_q;
    bd_n   = bd_q;
    bv_n   = 1'b0;
    fl_n   = 1'b0;
    ab_n   = 1'b0;
    if (ev_sat) begin
      if (act_q) begin
        ab_n   = 1'b1;
        act_n  = 1'b0;
        sr_n   = '0;
        left_n = LFW'(DW);
        drop_n = 1'b0;
      end
    end else if (ev_run) begin
      if (ev_len == LW'(FLAG_LEN)) begin
        fl_n   = 1'b1;
        act_n  = 1'b1;
        sr_n   = '0;
        left_n = LFW'(DW);
        drop_n = 1'b1;
      end else if (ev_len > LW'(FLAG_LEN)) begin
        ab_n   = act_q;
        act_n  = 1'b0;
        sr_n   = '0;
        left_n = LFW'(DW);
        drop_n = 1'b0;
      end else if (act_q) begin
        for (int i = 0; i < FLAG_LEN - 1; i++) begin
          if ((LW'(i) < ev_len) && !(i == 0 && drop_q)) begin
            sr_n = {logic'(i != 0), sr_n[DW-1:1]};
            if (left_n == LFW'(1)) begin
              bv_n   = 1'b1;
              bd_n   = sr_n;
              left_n = LFW'(DW);
            end else begin
              left_n = left_n - LFW'(1);
            end
          end
        end
        drop_n = (ev_len == LW'(FLAG_LEN - 1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      bd_q   <= '0;
      left_q <= LFW'(DW);
      act_q  <= 1'b0;
      drop_q <= 1'b0;
      bv_q   <= 1'b0;
      fl_q   <= 1'b0;
      ab_q   <= 1'b0;
    end else begin
      sr_q   <= sr_n;
      bd_q   <= bd_n;
      left_q <= left_n;
      act_q  <= act_n;
      drop_q <= drop_n;
      bv_q   <= bv_n;
      fl_q   <= fl_n;
      ab_q   <= ab_n;
    end
  end

  assign byte_vld  = bv_q;
  assign byte_data = bd_q;
  assign flag_det  = fl_q;
  assign abort_det = ab_q;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bv_q, fl_q, ab_q})) else $error("strobes overlap"); // R10

  AST_IDLE_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    bv_q |-> $past(act_q)) else $error("byte while idle"); // R9

  AST_FLAG_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    fl_q |-> (act_q && left_q == LFW'(DW))) else $error("flag left stale state"); // R6

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ab_q |-> (!act_q && left_q == LFW'(DW))) else $error("abort kept frame"); // R7

endmodule

// File: rtl/ax25rx_top.sv
module ax25rx_top
  import ax25rx_pkg::*;
#(
  parameter int OVS         = OVS_DEF,
  parameter int FLAG_LEN    = FLAG_LEN_DEF,
  parameter int DW          = DW_DEF,
  parameter int SYNC_STAGES = 2,
  localparam int LW         = len_width(FLAG_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          tone_in,
  output logic          byte_vld,
  output logic [DW-1:0] byte_data,
  output logic          flag_det,
  output logic          abort_det
);

  logic          tone_s;
  logic          ev_run, ev_sat;
  logic [LW-1:0] ev_len;

  ax25rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (tone_in),
    .d_sync  (tone_s)
  );

  ax25rx_runlen #(.OVS(OVS), .FLAG_LEN(FLAG_LEN)) u_runlen (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .din    (tone_s),
    .ev_run (ev_run),
    .ev_len (ev_len),
    .ev_sat (ev_sat)
  );

  ax25rx_deframe #(.FLAG_LEN(FLAG_LEN), .DW(DW)) u_deframe (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_run    (ev_run),
    .ev_len    (ev_len),
    .ev_sat    (ev_sat),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .flag_det  (flag_det),
    .abort_det (abort_det)
  );

  AST_STROBE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld || flag_det || abort_det) |-> $past(tick))
    else $error("strobe without tick"); // R1

endmodule

// File: tb/ax25rx_top_bench.sv
module ax25rx_top_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       tone_in = 1'b0;
  logic       byte_vld, flag_det, abort_det;
  logic [7:0] byte_data;

  int vectors = 0;
  int fails   = 0;
  bit started = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  ax25rx_top u_ax25rx_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tone_in(tone_in),
    .byte_vld(byte_vld), .byte_data(byte_data),
    .flag_det(flag_det), .abort_det(abort_det)
  );

  // ---------------- behavioural reference model ----------------
  bit m_s1, m_s2, m_last, m_act, m_drop;
  int m_run, m_sr, m_nb;
  bit e_bv, e_fl, e_ab;
  int e_bd;

  task automatic m_clear();
    m_sr = 0; m_nb = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_last = 0; m_act = 0; m_drop = 0;
      m_run = 30; m_clear();
      e_bv = 0; e_fl = 0; e_ab = 0; e_bd = 0;
    end else begin
      e_bv = 0; e_fl = 0; e_ab = 0;
      if (tick) begin
        if (m_s2 != m_last) begin
          int n;
          n = (m_run + 2) / 4;
          if (n < 1) n = 1;
          m_run = 1;
          if (n == 7) begin
            e_fl = 1; m_act = 1; m_clear(); m_drop = 1;
          end else if (n > 7) begin
            e_ab = m_act; m_act = 0; m_clear(); m_drop = 0;
          end else if (m_act) begin
            for (int k = 0; k < n; k++) begin
              if (!(k == 0 && m_drop)) begin
                m_sr = (m_sr >> 1) | ((k != 0) ? 128 : 0);
                m_nb++;
                if (m_nb == 8) begin e_bv = 1; e_bd = m_sr; m_nb = 0; end
              end
            end
            m_drop = (n == 6);
          end
        end else begin
          if (m_run == 29 && m_act) begin
            e_ab = 1; m_act = 0; m_clear(); m_drop = 0;
          end
          if (m_run < 30) m_run++;
        end
        m_last = m_s2;
      end
      m_s2 = m_s1;
      m_s1 = tone_in;
    end
  end

  // ---------------- per-cycle comparison ----------------
  int got_bytes[$];
  int n_flags = 0, n_aborts = 0;

  always @(negedge clk) begin
    if (rst_n && started && !done) begin
      vectors++;
      if (byte_vld !== e_bv || (e_bv && byte_data !== e_bd[7:0])) begin
        fails++;
        $display("FAIL R3 R4 byte: vld=%0b data=%02h expected vld=%0b data=%02h (R1 R2 R5)",
                 byte_vld, byte_data, e_bv, e_bd[7:0]);
      end
      if (flag_det !== e_fl) begin
        fails++;
        $display("FAIL R6 flag_det=%0b expected %0b", flag_det, e_fl);
      end
      if (abort_det !== e_ab) begin
        fails++;
        $display("FAIL R7 R8 abort_det=%0b expected %0b", abort_det, e_ab);
      end
      if ($countones({byte_vld, flag_det, abort_det}) > 1) begin
        fails++;
        $display("FAIL R10 strobes=%03b expected at most one set",
                 {byte_vld, flag_det, abort_det});
      end
      if (byte_vld === 1'b1) got_bytes.push_back(int'(byte_data));
      if (flag_det === 1'b1) n_flags++;
      if (abort_det === 1'b1) n_aborts++;
    end
  end

  // ---------------- stimulus helpers ----------------
  bit bits_q[$];
  int ones_run = 0;
  int jit_idx = 0;

  task automatic put_flag();
    bits_q.push_back(0);
    for (int k = 0; k < 6; k++) bits_q.push_back(1);
    bits_q.push_back(0);
    ones_run = 0;
  endtask

  task automatic put_byte(input int b);
    for (int k = 0; k < 8; k++) begin
      bit v;
      v = bit'((b >> k) & 1);
      bits_q.push_back(v);
      if (v) begin
        ones_run++;
        if (ones_run == 5) begin bits_q.push_back(0); ones_run = 0; end
      end else ones_run = 0;
    end
  endtask

  task automatic put_raw(input bit v);
    bits_q.push_back(v);
    ones_run = v ? ones_run + 1 : 0;
  endtask

  task automatic wait_ticks(input int k);
    for (int t = 0; t < k; t++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  // Send queued bits as NRZI intervals; the last interval is held tail ticks.
  task automatic send_bits(input int tail);
    int len;
    int jit;
    len = 0;
    while (bits_q.size() > 0) begin
      bit v;
      v = bits_q.pop_front();
      if (!v) begin
        if (len > 0) begin
          jit = (jit_idx % 3 == 0) ? 0 : ((jit_idx % 3 == 1) ? 1 : -1);
          jit_idx++;
          wait_ticks(4 * len + jit);
        end
        tone_in = ~tone_in;
        len = 1;
      end else begin
        len++;
      end
    end
    wait_ticks(tail);
  endtask

  // ---------------- watchdog ----------------
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired R1 actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  int exp_bytes[$];

  task automatic check(input bit ok, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  initial begin
    exp_bytes = '{8'hA5, 8'hFF, 8'h7E, 8'h00, 8'h3C, 8'hF0, 8'h12, 8'h81};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset leaves every strobe low
    check(byte_vld === 1'b0 && flag_det === 1'b0 && abort_det === 1'b0,
          "R9 reset strobes", int'({byte_vld, flag_det, abort_det}), 0);
    started = 1;
    wait_ticks(40); // idle line: saturation while idle must stay silent (R8 R9)

    // Frame 1: preamble flags, stuffed payload, closing flag, new frame
    put_flag(); put_flag(); put_flag();
    put_byte(8'hA5); put_byte(8'hFF); put_byte(8'h7E);
    put_byte(8'h00); put_byte(8'h3C); put_byte(8'hF0);
    put_flag();
    put_byte(8'h12);
    put_raw(0); put_raw(1); put_raw(0); put_raw(1); // partial, then steady tone
    send_bits(45);

    // After abort: byte without a flag must be ignored (R7 R9)
    put_byte(8'h55);
    put_flag(); put_flag();
    put_byte(8'h81);
    put_flag();
    send_bits(60);
    wait_ticks(4);

    check(got_bytes.size() == exp_bytes.size(), "R3 R4 byte count",
          got_bytes.size(), exp_bytes.size());
    for (int k = 0; k < exp_bytes.size(); k++) begin
      int a;
      a = (k < got_bytes.size()) ? got_bytes[k] : -1;
      check(a == exp_bytes[k], "R3 R5 byte value", a, exp_bytes[k]);
    end
    check(n_flags == 7, "R6 flag count", n_flags, 7);
    check(n_aborts == 2, "R7 R8 abort count", n_aborts, 2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule